// File: doc/BRIEF.md
# System-Clock Peripheral Prescaler

This block is a 13-bit free-running divider, clocked by the oscillator clock. It gives a set of peripheral consumers their time bases as single-cycle clock-enable pulses, and no divided clock leaves the block. Each consumer has its own 3-bit tap select. The select picks one of eight division ratios, so the consumers run at unrelated rates from one shared count.

A small state machine tracks the operating condition. The state is chosen from a power-mode code and a medium-speed enable:

- **ST_FULL**: the counter advances on every cycle.
- **ST_MED**: a 7-bit prescale counter lets the counter advance once every 16, 32, 64 or 128 cycles, chosen by a 2-bit ratio select.
- **ST_HALT**: used in the low-power modes. The counter and the prescaler are cleared and held, and no pulses are produced.

Transitions are re-evaluated on every edge:

- any state goes to **ST_HALT** when the mode code is a halting code;
- otherwise any state goes to **ST_MED** when the medium-speed enable is high;
- otherwise any state goes to **ST_FULL**.

Reset enters **ST_FULL** with all counts at zero. Software has no path to read or write the counter.

Top module: `sysclk_psc`

## Requirements
- R1: While the asynchronous active-low reset is asserted, all enables are low and the count is zero. After release in full mode, a consumer whose tap divides by D gives its first pulse in the D-th cycle after release.
- R2: In ST_FULL the count advances by one every cycle. Tap codes 0..7 divide by 2, 4, 8, 32, 128, 512, 2048 and 8192. The enable is high for exactly one cycle each time the count's low log2(D) bits return to zero.
- R3: In ST_MED, ratio codes 0..3 make the count advance once every 16, 32, 64 or 128 cycles. The advance happens in the cycle in which the prescale count equals the ratio minus one, and the prescale count then restarts at zero.
- R4: If the ratio select is lowered while the prescale count already exceeds the new ratio minus one, the count advances in the next cycle and the prescale count restarts at zero.
- R5: Mode codes 2, 3, 4 and 5 (the standby, watch, subactive and subsleep conditions) select ST_HALT. In that state the count and the prescale count are cleared, and every enable stays low whatever the medium-speed enable and the tap selects are.
- R6: On leaving ST_HALT the count resumes from zero, so the first pulse of a divide-by-D tap comes only after D advances.
- R7: Each consumer's enable follows its own tap select only. Changing one select does not change the pulses of any other consumer.
- R8: The mode code and the medium-speed enable are registered into the state on one edge, and the count acts on that state at the following edge. The ratio and tap selects act at the edge where they are sampled.
- R9: Mode codes 0, 1, 6 and 7 keep the counter running, in ST_FULL or ST_MED depending on the medium-speed enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_mode_i | input | 3 | Power-mode code (2..5 halt the counter) |
| med_en_i | input | 1 | Medium-speed enable |
| med_ratio_i | input | 2 | Medium-speed ratio: 0=/16, 1=/32, 2=/64, 3=/128 |
| tap_sel_i | input | N_CONS*3 | Per-consumer tap code, consumer i in bits [3i+2:3i] |
| ena_o | output | N_CONS | Per-consumer single-cycle enable pulse |

## Verification
An enable pulse is registered. It is visible in the cycle that follows the edge at which the count reaches its wrap value, so it is due on that edge, while the ratio and tap selects used are the ones present on that same edge. A mode or medium-speed change is due one edge later, because it first passes through the state register. The first pulse after leaving the halt state therefore arrives D+1 cycles after the mode input changes. The bench changes inputs only on falling edges and keeps a cycle-level reference model updated on the rising edges. It compares every enable against that model on the following falling edge, and it also measures first-pulse latencies directly against the cycle counts above.

// File: rtl/sysclk_psc_pkg.sv
package sysclk_psc_pkg;

    typedef enum logic [1:0] {
        ST_FULL = 2'd0,
        ST_MED  = 2'd1,
        ST_HALT = 2'd2
    } psc_state_e;

    typedef enum logic [2:0] {
        PM_RUN      = 3'd0,
        PM_SLEEP    = 3'd1,
        PM_STANDBY  = 3'd2,
        PM_WATCH    = 3'd3,
        PM_SUBACT   = 3'd4,
        PM_SUBSLEEP = 3'd5,
        PM_RSV6     = 3'd6,
        PM_RSV7     = 3'd7
    } pwr_mode_e;

    localparam int TAP_SEL_W = 3;
    localparam int RATIO_W   = 2;

    function automatic logic mode_halts(input logic [2:0] code);
        return (code >= 3'(PM_STANDBY)) && (code <= 3'(PM_SUBSLEEP));
    endfunction

endpackage

// File: rtl/psc_mode_fsm.sv
module psc_mode_fsm
    import sysclk_psc_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [2:0] pwr_mode_i,
    input  logic       med_en_i,
    input  logic       tick_i,
    output logic       med_run_o,
    output logic       clear_o,
    output logic       advance_o
);

    psc_state_e state_q, state_d;
    logic       halt_req;

    assign halt_req = mode_halts(pwr_mode_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FULL, ST_MED, ST_HALT: begin
                if (halt_req)      state_d = ST_HALT;
                else if (med_en_i) state_d = ST_MED;
                else               state_d = ST_FULL;
            end
            default: state_d = ST_FULL;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_FULL;
        else         state_q <= state_d;
    end

    always_comb begin
        med_run_o = 1'b0;
        clear_o   = 1'b0;
        advance_o = 1'b0;
        unique case (state_q)
            ST_FULL: advance_o = 1'b1;
            ST_MED: begin
                med_run_o = 1'b1;
                advance_o = tick_i;
            end
            ST_HALT: clear_o = 1'b1;
            default: clear_o = 1'b1;
        endcase
    end

    AST_HALT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_halts(pwr_mode_i) |=> (state_q == ST_HALT)); // R5
    AST_RUN_MODES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mode_halts(pwr_mode_i) && !med_en_i) |=> (state_q == ST_FULL)); // R9

endmodule

// File: rtl/psc_med_gate.sv
module psc_med_gate
    import sysclk_psc_pkg::*;
#(
    parameter int PRE_W = 7
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               run_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               tick_o
);

    localparam logic [PRE_W-1:0] BASE = PRE_W'(16);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] term;

    assign term   = (BASE << ratio_i) - PRE_W'(1);
    assign tick_o = run_i && (pre_q >= term);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     pre_q <= '0;
        else if (!run_i) pre_q <= '0;
        else if (tick_o) pre_q <= '0;
        else             pre_q <= pre_q + PRE_W'(1);
    end

    AST_PRE_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (pre_q == '0)); // R5
    AST_PRE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && pre_q >= term) |=> (pre_q == '0)); // R4

endmodule

// File: rtl/psc_counter.sv
module psc_counter #(
    parameter int CNT_W = 13
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             advance_i,
    output logic [CNT_W-1:0] cnt_next_o
);

    logic [CNT_W-1:0] cnt_q;

    assign cnt_next_o = cnt_q + CNT_W'(1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        cnt_q <= '0;
        else if (clear_i)   cnt_q <= '0;
        else if (advance_i) cnt_q <= cnt_next_o;
    end

    AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (cnt_q == '0)); // R5
    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (advance_i && !clear_i) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R2
    AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!advance_i && !clear_i) |=> $stable(cnt_q)); // R3

endmodule

// File: rtl/psc_tap.sv
module psc_tap
    import sysclk_psc_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 advance_i,
    input  logic [CNT_W-1:0]     cnt_next_i,
    input  logic [TAP_SEL_W-1:0] sel_i,
    output logic                 ena_o
);

    logic [CNT_W-1:0] mask;
    int unsigned      len;

    always_comb begin
        unique case (sel_i)
            3'd0: len = 1;
            3'd1: len = 2;
            3'd2: len = 3;
            3'd3: len = 5;
            3'd4: len = 7;
            3'd5: len = 9;
            3'd6: len = 11;
            3'd7: len = CNT_W;
            default: len = CNT_W;
        endcase
        mask = CNT_W'((64'(1) << len) - 64'(1));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ena_o <= 1'b0;
        else         ena_o <= advance_i && ((cnt_next_i & mask) == '0);
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ena_o |=> !ena_o); // R2

endmodule

// File: rtl/sysclk_psc.sv
module sysclk_psc
    import sysclk_psc_pkg::*;
#(
    parameter int N_CONS = 4,
    parameter int CNT_W  = 13,
    parameter int PRE_W  = 7
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic [2:0]                  pwr_mode_i,
    input  logic                        med_en_i,
    input  logic [RATIO_W-1:0]          med_ratio_i,
    input  logic [N_CONS*TAP_SEL_W-1:0] tap_sel_i,
    output logic [N_CONS-1:0]           ena_o
);

    logic             tick;
    logic             med_run;
    logic             clear;
    logic             advance;
    logic [CNT_W-1:0] cnt_next;

    psc_mode_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pwr_mode_i (pwr_mode_i),
        .med_en_i   (med_en_i),
        .tick_i     (tick),
        .med_run_o  (med_run),
        .clear_o    (clear),
        .advance_o  (advance)
    );

    psc_med_gate #(.PRE_W(PRE_W)) u_gate (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (med_run),
        .ratio_i (med_ratio_i),
        .tick_o  (tick)
    );

    psc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clear_i    (clear),
        .advance_i  (advance),
        .cnt_next_o (cnt_next)
    );

    for (genvar gi = 0; gi < N_CONS; gi++) begin : g_tap
        psc_tap #(.CNT_W(CNT_W)) u_tap (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .advance_i  (advance),
            .cnt_next_i (cnt_next),
            .sel_i      (tap_sel_i[gi*TAP_SEL_W +: TAP_SEL_W]),
            .ena_o      (ena_o[gi])
        );
    end

    AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear |=> (ena_o == '0)); // R5
    AST_MED_SPARSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (med_run && !tick) |=> (ena_o == '0)); // R3

endmodule

// File: tb/sysclk_psc_tb.sv
`timescale 1ns/1ps
module sysclk_psc_tb;

    localparam int N = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [2:0]     mode = 3'd0;
    logic           med_en = 1'b0;
    logic [1:0]     ratio = 2'd0;
    logic [N*3-1:0] sel = '0;
    logic [N-1:0]   ena;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sysclk_psc u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .pwr_mode_i  (mode),
        .med_en_i    (med_en),
        .med_ratio_i (ratio),
        .tap_sel_i   (sel),
        .ena_o       (ena)
    );

    function automatic int tap_len(input logic [2:0] c);
        case (c)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 3;
            3'd3: return 5;
            3'd4: return 7;
            3'd5: return 9;
            3'd6: return 11;
            default: return 13;
        endcase
    endfunction

    function automatic int ratio_term(input logic [1:0] r);
        return (16 << r) - 1;
    endfunction

    function automatic bit halting(input logic [2:0] m);
        return (m >= 3'd2) && (m <= 3'd5);
    endfunction

    // Reference model: 0 full, 1 medium, 2 halt
    int         m_state;
    int         m_pre;
    int         m_cnt;
    logic [N-1:0] m_ena;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state <= 0; m_pre <= 0; m_cnt <= 0; m_ena <= '0;
        end else begin
            bit adv;
            adv = (m_state == 0) || (m_state == 1 && m_pre >= ratio_term(ratio));
            m_state <= halting(mode) ? 2 : (med_en ? 1 : 0);
            if (m_state == 1) m_pre <= (m_pre >= ratio_term(ratio)) ? 0 : m_pre + 1;
            else              m_pre <= 0;
            if (m_state == 2)  m_cnt <= 0;
            else if (adv)      m_cnt <= (m_cnt + 1) % 8192;
            for (int i = 0; i < N; i++)
                m_ena[i] <= adv && ((((m_cnt + 1) % 8192) % (1 << tap_len(sel[i*3 +: 3]))) == 0);
        end
    end

    int since;
    int first_seen [N];

    task automatic arm();
        since = 0;
        for (int i = 0; i < N; i++) first_seen[i] = -1;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic run(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            since++;
            for (int i = 0; i < N; i++)
                if (first_seen[i] < 0 && ena[i]) first_seen[i] = since;
            check(ena === m_ena, tag, int'(ena), int'(m_ena));
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 190000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_up();
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        sel = {3'd1, 3'd3, 3'd7, 3'd0};
        repeat (3) @(negedge clk);
        check(ena == '0, "R1 reset enables", int'(ena), 0);
        rst_n = 1'b1;
        arm();
        // R1 R2: full mode after release, 8192 wrap observed on consumer 1
        run(8300, "R2 full mode");
        check(first_seen[0] == 2,    "R1 first /2",    first_seen[0], 2);
        check(first_seen[1] == 8192, "R1 first /8192", first_seen[1], 8192);
        check(first_seen[2] == 32,   "R1 first /32",   first_seen[2], 32);
        check(first_seen[3] == 4,    "R1 first /4",    first_seen[3], 4);

        // R7: change some selects, others keep their rates
        sel[2:0] = 3'd2; sel[8:6] = 3'd4;
        run(3000, "R7 independent selects");
        sel = {3'd6, 3'd5, 3'd1, 3'd0};
        run(3000, "R7 independent selects");

        // R3: each medium ratio
        sel = {3'd2, 3'd1, 3'd0, 3'd0};
        med_en = 1'b1;
        for (int r = 0; r < 4; r++) begin
            ratio = 2'(r);
            run(2200, "R3 medium ratio");
        end

        // R4: lower ratio while prescale is high
        ratio = 2'd3;
        run(100, "R4 ratio drop");
        ratio = 2'd0;
        run(80, "R4 ratio drop");

        // R5: each halting mode, medium enable and selects varied
        for (int m = 2; m <= 5; m++) begin
            mode = 3'(m);
            med_en = m[0];
            sel = 12'($urandom);
            run(60, "R5 halt quiet");
            check(ena == '0, "R5 halt enables low", int'(ena), 0);
        end

        // R6 R8: resume from halt in full mode, /8 tap on consumer 0
        sel = {3'd3, 3'd1, 3'd0, 3'd2};
        med_en = 1'b0;
        mode = 3'd0;
        arm();
        run(40, "R6 resume");
        check(first_seen[0] == 9, "R6 R8 first /8 after resume", first_seen[0], 9);
        check(first_seen[1] == 3, "R6 R8 first /2 after resume", first_seen[1], 3);

        // R6: resume in medium mode
        mode = 3'd4;
        run(10, "R5 halt");
        mode = 3'd1; med_en = 1'b1; ratio = 2'd0;
        arm();
        run(100, "R6 medium resume");
        check(first_seen[1] == 33, "R6 first /2 medium resume", first_seen[1], 33);

        // R9: non-halting codes keep counting
        for (int m = 6; m <= 7; m++) begin
            mode = 3'(m);
            med_en = 1'b0;
            run(300, "R9 running codes");
        end
        mode = 3'd1;
        run(300, "R9 running codes");

        // Random segments
        for (int s = 0; s < 140; s++) begin
            int pick;
            pick = $urandom_range(0, 9);
            mode   = (pick < 2) ? 3'($urandom_range(2, 5)) :
                     ((pick < 4) ? 3'($urandom_range(6, 7)) : 3'($urandom_range(0, 1)));
            med_en = 1'($urandom);
            ratio  = 2'($urandom);
            sel    = 12'($urandom);
            run($urandom_range(20, 600), "R8 random mix");
        end

        finish_up();
    end

endmodule